// File: doc/BRIEF.md
# Iterative Butterfly-Shuffle Engine

This block takes a set of sixteen words and runs a fixed number of rounds over them. In each round it pairs adjacent slots and replaces each pair (a, b) with (a+b, a-b), using wrapping arithmetic at the word width. It then moves every slot to a new position through a perfect-shuffle rewiring, which feeds the next round. Once the last round is done, the sixteen words are presented together with a one-cycle completion strobe.

All pair operations of all rounds go through one operator, issued one per cycle. The operator is cut into a parameterised number of pipeline stages. A pair of the next round can depend on results that are still inside the pipeline. The issue sequencer tracks which slots hold valid data and inserts bubble cycles until both inputs of the next pair have come back. The operands sit in two banks that alternate by round parity, so results of one round never overwrite inputs that are still waiting to issue.

A run begins with a parallel load and a start strobe. The caller waits for the done strobe and reads the result bus, which holds its value until the next run completes.

Top module: `iter_eng`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `busy` and `done` are 0 and `dout` is all zeros.
- R2: A `start` pulse while `busy` is 0 captures `din` bits [i*W +: W] as slot i, for i from 0 to 15, and `busy` is 1 from the next cycle onward.
- R3: Pair k (k = 0..7) of a round reads slots 2k and 2k+1 as a and b. It writes (a+b) mod 2^W to the position of slot 2k and (a-b) mod 2^W to the position of slot 2k+1, before rewiring.
- R4: After the pair step of every round, including the last, the word in slot i moves to slot ((i<<1) | (i>>3)) mod 16. This is a 4-bit rotate left.
- R5: After exactly ITERS rounds, `dout` bits [i*W +: W] carry final slot i.
- R6: `done` is high for exactly one cycle per run. `busy` is 0 in that cycle and stays 0 until the next accepted start.
- R7: A `start` pulse while `busy` is 1 has no effect: the running set completes with results from its own operands, and no extra `done` follows.
- R8: At most PIPE pair operations are in flight. No result returns without a matching issue. Because the operator accepts one pair per cycle, `done` comes between 8*ITERS+PIPE+1 and ITERS*(9+PIPE)+2 cycles after the accepting clock edge.
- R9: `dout` changes only in a cycle where `done` is high, and it holds its value between runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe, honoured only while idle |
| din | input | 16*W | Sixteen operand words, slot i at bits [i*W +: W] |
| busy | output | 1 | High from the cycle after a load until done |
| done | output | 1 | One-cycle completion strobe |
| dout | output | 16*W | Sixteen result words, slot i at bits [i*W +: W] |

## Verification
The bench builds the engine with ITERS = 4, PIPE = 10 and W = 16. With these values every round after the first runs into the cross-round dependency, so the stall logic is exercised on each boundary while a run stays short. Four rounds also cover an even final bank parity and a shuffle that has gone fully around the 4-bit rotate. The 16-bit width lets the sum and difference wrap when the bench uses all-ones and single-large-word operand sets.

// File: rtl/iter_eng_pkg.sv
package iter_eng_pkg;
  localparam int LANES   = 16;
  localparam int PAIRS   = LANES / 2;
  localparam int SLOT_W  = $clog2(LANES);
  localparam int PAIR_W  = $clog2(PAIRS);

  typedef struct packed {
    logic              par;
    logic [PAIR_W-1:0] pair;
  } tag_t;

  // perfect shuffle: rotate slot index left by one
  function automatic logic [SLOT_W-1:0] shuf(input logic [SLOT_W-1:0] i);
    return {i[SLOT_W-2:0], i[SLOT_W-1]};
  endfunction
endpackage

// File: rtl/iter_eng_pipe.sv
module iter_eng_pipe
  import iter_eng_pkg::*;
#(
  parameter int W    = 16,
  parameter int PIPE = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  tag_t         in_tag,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_v,
  output tag_t         out_tag,
  output logic [W-1:0] out_s,
  output logic [W-1:0] out_d
);
  logic [PIPE-1:0] v;
  tag_t            tg [PIPE];
  logic [W-1:0]    s  [PIPE];
  logic [W-1:0]    d  [PIPE];

  always_ff @(posedge clk) begin
    if (rst) v[0] <= 1'b0;
    else     v[0] <= in_v;
    tg[0] <= in_tag;
    s[0]  <= in_a + in_b;
    d[0]  <= in_a - in_b;
  end

  for (genvar g = 1; g < PIPE; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) v[g] <= 1'b0;
      else     v[g] <= v[g-1];
      tg[g] <= tg[g-1];
      s[g]  <= s[g-1];
      d[g]  <= d[g-1];
    end
  end

  assign out_v   = v[PIPE-1];
  assign out_tag = tg[PIPE-1];
  assign out_s   = s[PIPE-1];
  assign out_d   = d[PIPE-1];
endmodule

// File: rtl/iter_eng_store.sv
module iter_eng_store
  import iter_eng_pkg::*;
#(
  parameter int W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [LANES*W-1:0] load_data,
  input  tag_t               rd_tag,
  input  logic               rd_take,
  output logic [W-1:0]       rd_a,
  output logic [W-1:0]       rd_b,
  output logic               rd_ok,
  input  logic               wr_v,
  input  tag_t               wr_tag,
  input  logic [W-1:0]       wr_s,
  input  logic [W-1:0]       wr_d,
  input  logic               fin_par,
  output logic [LANES*W-1:0] fin_words
);
  logic [W-1:0]     mem [2][LANES];
  logic [LANES-1:0] vld [2];

  logic [SLOT_W-1:0] src0, src1, dst0, dst1;
  assign src0 = {rd_tag.pair, 1'b0};
  assign src1 = {rd_tag.pair, 1'b1};
  assign dst0 = shuf({wr_tag.pair, 1'b0});
  assign dst1 = shuf({wr_tag.pair, 1'b1});

  assign rd_a  = mem[rd_tag.par][src0];
  assign rd_b  = mem[rd_tag.par][src1];
  assign rd_ok = vld[rd_tag.par][src0] & vld[rd_tag.par][src1];

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < LANES; i++) mem[0][i] <= load_data[i*W +: W];
    end else if (wr_v) begin
      mem[~wr_tag.par][dst0] <= wr_s;
      mem[~wr_tag.par][dst1] <= wr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld[0] <= '0;
      vld[1] <= '0;
    end else if (load) begin
      vld[0] <= '1;
      vld[1] <= '0;
    end else begin
      if (rd_take) begin
        vld[rd_tag.par][src0] <= 1'b0;
        vld[rd_tag.par][src1] <= 1'b0;
      end
      if (wr_v) begin
        vld[~wr_tag.par][dst0] <= 1'b1;
        vld[~wr_tag.par][dst1] <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_fin
    assign fin_words[g*W +: W] = mem[fin_par][g];
  end
endmodule

// File: rtl/iter_eng_seq.sv
module iter_eng_seq
  import iter_eng_pkg::*;
#(
  parameter int ITERS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic src_ok,
  input  logic ret_v,
  output logic busy,
  output logic fire,
  output tag_t tag,
  output logic fin
);
  localparam int TOTAL = PAIRS * ITERS;
  localparam int IW    = $clog2(ITERS + 1);
  localparam int RW    = $clog2(TOTAL + 1);

  logic [IW-1:0]     it_cnt;
  logic [PAIR_W-1:0] pair;
  logic [RW-1:0]     ret_cnt;

  assign tag.par  = it_cnt[0];
  assign tag.pair = pair;
  assign fire     = busy && (it_cnt != IW'(ITERS)) && src_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      it_cnt  <= '0;
      pair    <= '0;
      ret_cnt <= '0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (!busy && start) begin
        busy    <= 1'b1;
        it_cnt  <= '0;
        pair    <= '0;
        ret_cnt <= '0;
      end
      if (fire) begin
        pair <= pair + 1'b1;
        if (pair == PAIR_W'(PAIRS - 1)) it_cnt <= it_cnt + 1'b1;
      end
      if (ret_v) begin
        ret_cnt <= ret_cnt + 1'b1;
        if (ret_cnt == RW'(TOTAL - 1)) fin <= 1'b1;
      end
      if (fin) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/iter_eng.sv
module iter_eng
  import iter_eng_pkg::*;
#(
  parameter int W     = 16,
  parameter int ITERS = 256,
  parameter int PIPE  = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [LANES*W-1:0]      din,
  output logic                    busy,
  output logic                    done,
  output logic [LANES*W-1:0]      dout
);
  localparam logic FIN_PAR = ITERS[0];

  logic               seq_fire, seq_fin, src_ok, pipe_ov, load;
  tag_t               seq_tag, pipe_tag;
  logic [W-1:0]       op_a, op_b, res_s, res_d;
  logic [LANES*W-1:0] fin_words;

  assign load = start && !busy;

  iter_eng_seq #(.ITERS(ITERS)) u_seq (
    .clk(clk), .rst(rst), .start(start), .src_ok(src_ok), .ret_v(pipe_ov),
    .busy(busy), .fire(seq_fire), .tag(seq_tag), .fin(seq_fin)
  );

  iter_eng_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .load(load), .load_data(din),
    .rd_tag(seq_tag), .rd_take(seq_fire), .rd_a(op_a), .rd_b(op_b), .rd_ok(src_ok),
    .wr_v(pipe_ov), .wr_tag(pipe_tag), .wr_s(res_s), .wr_d(res_d),
    .fin_par(FIN_PAR), .fin_words(fin_words)
  );

  iter_eng_pipe #(.W(W), .PIPE(PIPE)) u_pipe (
    .clk(clk), .rst(rst), .in_v(seq_fire), .in_tag(seq_tag), .in_a(op_a), .in_b(op_b),
    .out_v(pipe_ov), .out_tag(pipe_tag), .out_s(res_s), .out_d(res_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      dout <= '0;
    end else begin
      done <= seq_fin;
      if (seq_fin) dout <= fin_words;
    end
  end
endmodule

// File: rtl/iter_eng_chk.sv
module iter_eng_chk #(
  parameter int W    = 16,
  parameter int PIPE = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [16*W-1:0] dout,
  input logic            fire,
  input logic            ret_v
);
  int inflight;

  always_ff @(posedge clk) begin
    if (rst) inflight <= 0;
    else     inflight <= inflight + (fire ? 1 : 0) - (ret_v ? 1 : 0);
  end

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> $past(start));
  // R9
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst) !$stable(dout) |-> done);
  // R8
  inflight_max_chk: assert property (@(posedge clk) disable iff (rst) inflight <= PIPE);
  // R8
  ret_match_chk: assert property (@(posedge clk) disable iff (rst) ret_v |-> inflight > 0);
endmodule

bind iter_eng iter_eng_chk #(.W(W), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .dout(dout),
  .fire(seq_fire), .ret_v(pipe_ov)
);

// File: tb/iter_eng_bench.sv
module iter_eng_bench;
  localparam int W  = 16;
  localparam int IT = 4;
  localparam int PP = 10;
  localparam int LN = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [LN*W-1:0] din = '0;
  logic            busy, done;
  logic [LN*W-1:0] dout;

  always #2.5 clk = ~clk;

  iter_eng #(.W(W), .ITERS(IT), .PIPE(PP)) u_iter_eng (
    .clk(clk), .rst(rst), .start(start), .din(din),
    .busy(busy), .done(done), .dout(dout)
  );

  int checks = 0, fails = 0, cyc = 0, done_cnt = 0;
  logic [LN*W-1:0] exp_q [$];
  int              t0_q  [$];
  logic [LN*W-1:0] last_exp = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R3 R4 R5 reference: pair step then rotate-left shuffle, IT rounds
  function automatic logic [LN*W-1:0] model(input logic [LN*W-1:0] in);
    logic [W-1:0] s [LN];
    logic [W-1:0] t [LN];
    logic [LN*W-1:0] o;
    for (int i = 0; i < LN; i++) s[i] = in[i*W +: W];
    for (int r = 0; r < IT; r++) begin
      for (int k = 0; k < LN/2; k++) begin
        t[2*k]   = s[2*k] + s[2*k+1];
        t[2*k+1] = s[2*k] - s[2*k+1];
      end
      for (int i = 0; i < LN; i++) s[((i << 1) | (i >> 3)) & 15] = t[i];
    end
    for (int i = 0; i < LN; i++) o[i*W +: W] = s[i];
    return o;
  endfunction

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && done) begin
      done_cnt++;
      chk(busy == 1'b0, "R6 busy low with done", 64'(busy), 64'd0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected done", 64'd1, 64'd0);
      end else begin
        logic [LN*W-1:0] e;
        int lat, t0;
        e  = exp_q.pop_front();
        t0 = t0_q.pop_front();
        last_exp = e;
        for (int i = 0; i < LN; i++)
          chk(dout[i*W +: W] == e[i*W +: W], $sformatf("R5 word %0d", i),
              64'(dout[i*W +: W]), 64'(e[i*W +: W]));
        lat = cyc - t0 - 1;
        chk(lat >= 8*IT + PP + 1 && lat <= IT*(9 + PP) + 2, "R8 latency window",
            64'(lat), 64'(8*IT + PP + 1));
      end
    end
  end

  task automatic run_set(input logic [LN*W-1:0] v, input bit poke);
    int target;
    @(negedge clk);
    while (busy) @(negedge clk);
    target = done_cnt + 1;
    exp_q.push_back(model(v));
    t0_q.push_back(cyc);
    din   = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    din   = ~v;
    chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      repeat (5) @(negedge clk);
      din   = {LN{16'h1234}};
      start = 1'b1; // R7 ignored while busy
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R7 still busy", 64'(busy), 64'd1);
    end
    while (done_cnt < target) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(done_cnt == target, "R7 single done", 64'(done_cnt), 64'(target));
    chk(dout == last_exp, "R9 dout held", dout[63:0], last_exp[63:0]);
    chk(busy == 1'b0, "R6 idle after done", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [LN*W-1:0] v;
    repeat (4) @(negedge clk);
    // R1 during reset
    chk(busy == 1'b0, "R1 busy in reset", 64'(busy), 64'd0);
    chk(done == 1'b0, "R1 done in reset", 64'(done), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
    chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
    chk(dout == '0, "R1 dout after reset", dout[63:0], 64'd0);

    for (int i = 0; i < LN; i++) v[i*W +: W] = 16'(i + 1);
    run_set(v, 1'b0);                  // R3 R4 ascending
    run_set('0, 1'b0);                 // zeros
    run_set({LN{16'hFFFF}}, 1'b1);     // wrap, with R7 poke
    v = '0; v[5*W +: W] = 16'h8001;
    run_set(v, 1'b0);                  // single large word
    for (int i = 0; i < LN; i++) v[i*W +: W] = 16'((i * 16'h1F3D) ^ 16'hA5C3);
    run_set(v, 1'b1);
    chk(exp_q.size() == 0, "R5 all results seen", 64'(exp_q.size()), 64'd0);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule